// File: doc/BRIEF.md
# ADC Serial Output Shift Engine

This block is the serial output stage of a 12-bit sampling converter that acts as a slave on an SPI-style link. A parallel port stands in for the analog core and supplies the conversion word. The master drives an active-low select and a serial clock. The block follows one frame through a sample window, a low null bit, the word sent most significant bit first, the same word sent again least significant bit first, and then a run of zeros that lasts as long as the clock keeps running. An output enable stands in for a pad in high impedance. A flag marks the point where the converter would power down.

The select and serial clock are asynchronous to the block clock `clk_i`. Each one passes through a synchronizer and an edge detector. Every action then runs on a detected edge of the serial clock or of the select. The serial output changes only after a detected falling edge of the serial clock, or when the select rises and the frame aborts.

Top module: `adc_sout`

## Requirements
- R1: While reset is asserted, and right after it, `state_o` is idle (0), `sdo_oe_o` is 0 and `pdn_o` is 0.
- R2: If `cs_ni` is low when reset releases, the block ignores serial clocks and stays idle until `cs_ni` has gone high and then low again.
- R3: `sdo_oe_o` is 0 while the state is idle or sample, and 1 from the null bit until the frame ends.
- R4: A falling `cs_ni` moves the state to sample (1). The state moves to null (2) on the second falling serial clock edge that follows the first rising edge after the select fell.
- R5: In the null state, `sdo_o` is 0.
- R6: The next 12 falling edges drive bits 11 down to 0 of the word on `sdo_o`, with the state at msb (3).
- R7: The next 11 falling edges drive bits 1 up to 11 on `sdo_o`, with the state at lsb (4). Bit 0 is not repeated.
- R8: Every falling edge after that keeps the state at zeros (5) and `sdo_o` at 0, with no limit on their number.
- R9: `pdn_o` is 0 until the last msb-first bit has been sent. It is 1 in the lsb and zeros states.
- R10: `sdo_o` does not change during the high phase of the serial clock.
- R11: The word is captured from `conv_word_i` when the sample window closes. Later changes to `conv_word_i` do not affect that frame.
- R12: A rising `cs_ni` in any state returns the block to idle, with `sdo_oe_o` and `pdn_o` at 0.
- R13: `state_o` uses the encoding idle=0, sample=1, null=2, msb=3, lsb=4, zeros=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from the master, active low |
| sclk_i | input | 1 | Serial clock from the master |
| conv_word_i | input | DATA_W | Conversion result from the core |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data line; 0 means high impedance |
| pdn_o | output | 1 | Power-down indicator |
| state_o | output | 3 | Current frame phase |

## Verification
An edge on `cs_ni` or `sclk_i` passes through SYNC_STAGES synchronizer flops and then one state register. The effect on the outputs therefore shows after the (SYNC_STAGES+1)-th rising `clk_i` edge, which is the third edge with the default setting. The bench drives its inputs on falling `clk_i` edges and holds each serial clock phase for four block clocks. It samples at the end of each phase, when every result is already due. The high-phase check for R10 is taken at the same point, so any change on `sdo_o` caused by the rising serial edge would already be visible there.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_NULL   = 3'd2,
    ST_MSB    = 3'd3,
    ST_LSB    = 3'd4,
    ST_ZEROS  = 3'd5
  } state_e;
endpackage

// File: rtl/adc_sout_edge.sv
module adc_sout_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_sout_ctrl.sv
module adc_sout_ctrl
  import adc_sout_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  output state_e           state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             upd_o,
  output logic             zero_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  state_e           st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rise_seen_q, rise_seen_d;
  logic             fall_cnt_q, fall_cnt_d;

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    rise_seen_d = rise_seen_q;
    fall_cnt_d  = fall_cnt_q;
    load_o      = 1'b0;
    upd_o       = 1'b0;
    zero_o      = 1'b0;
    if (cs_rise_i) begin
      st_d   = ST_IDLE;
      upd_o  = 1'b1;
      zero_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cs_fall_i) begin
          st_d        = ST_SAMPLE;
          rise_seen_d = 1'b0;
          fall_cnt_d  = 1'b0;
        end
        ST_SAMPLE: begin
          if (sclk_rise_i) rise_seen_d = 1'b1;
          // window closes on the second fall after the first rise
          if (sclk_fall_i && rise_seen_q) begin
            if (fall_cnt_q) begin
              st_d   = ST_NULL;
              load_o = 1'b1;
              upd_o  = 1'b1;
              zero_o = 1'b1;
            end else begin
              fall_cnt_d = 1'b1;
            end
          end
        end
        ST_NULL: if (sclk_fall_i) begin
          st_d  = ST_MSB;
          idx_d = LAST;
          upd_o = 1'b1;
        end
        ST_MSB: if (sclk_fall_i) begin
          upd_o = 1'b1;
          if (idx_q == '0) begin
            st_d  = ST_LSB;
            idx_d = IDX_W'(1);
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
        ST_LSB: if (sclk_fall_i) begin
          upd_o = 1'b1;
          if (idx_q == LAST) begin
            st_d   = ST_ZEROS;
            zero_o = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_ZEROS: if (sclk_fall_i) begin
          upd_o  = 1'b1;
          zero_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      rise_seen_q <= 1'b0;
      fall_cnt_q  <= 1'b0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      rise_seen_q <= rise_seen_d;
      fall_cnt_q  <= fall_cnt_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_d;
endmodule

// File: rtl/adc_sout_shreg.sv
module adc_sout_shreg #(
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  input  logic              upd_i,
  input  logic              zero_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] word_o,
  output logic              sdo_o
);
  logic [DATA_W-1:0] word_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
    end else begin
      if (load_i) word_q <= word_i;
      if (upd_i)  sdo_q  <= zero_i ? 1'b0 : word_q[idx_i];
    end
  end

  assign word_o = word_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/adc_sout.sv
module adc_sout
  import adc_sout_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] conv_word_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              pdn_o,
  output logic [2:0]        state_o
);
  logic cs_lvl, cs_rise, cs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic load, upd, zero;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] word_q;
  state_e            state;

  // select chain resets low: a select held low through reset yields no fall
  adc_sout_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cs_edge (
    .clk_i, .rst_ni, .async_i(cs_ni),
    .lvl_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_sout_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_edge (
    .clk_i, .rst_ni, .async_i(sclk_i),
    .lvl_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_sout_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_rise_i(cs_rise), .cs_fall_i(cs_fall),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .state_o(state), .idx_o(idx),
    .load_o(load), .upd_o(upd), .zero_o(zero)
  );

  adc_sout_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i, .rst_ni,
    .word_i(conv_word_i), .load_i(load), .upd_i(upd), .zero_i(zero),
    .idx_i(idx), .word_o(word_q), .sdo_o(sdo_o)
  );

  assign sdo_oe_o = (state != ST_IDLE) && (state != ST_SAMPLE);
  assign pdn_o    = (state == ST_LSB) || (state == ST_ZEROS);
  assign state_o  = state;

  logic unused_lvl;
  assign unused_lvl = cs_lvl ^ sclk_lvl;
endmodule

// File: rtl/adc_sout_chk.sv
module adc_sout_chk
  import adc_sout_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input state_e            state,
  input logic              sdo_o,
  input logic              pdn_o,
  input logic              sclk_fall,
  input logic              cs_rise,
  input logic [DATA_W-1:0] word_q
);
  p_sdo_on_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_o != $past(sdo_o)) |-> $past(sclk_fall || cs_rise));

  p_abort_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (state == ST_IDLE));

  p_null_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_NULL) |-> !sdo_o);

  p_zeros_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ZEROS) |-> !sdo_o);

  p_zeros_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ZEROS && !cs_rise) |=> (state == ST_ZEROS));

  p_pdn_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_o && !cs_rise) |=> pdn_o);

  p_word_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {ST_NULL, ST_MSB, ST_LSB, ST_ZEROS}) |=> $stable(word_q));

  p_enc_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {ST_IDLE, ST_SAMPLE, ST_NULL, ST_MSB, ST_LSB, ST_ZEROS}));
endmodule

bind adc_sout adc_sout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state(state), .sdo_o(sdo_o), .pdn_o(pdn_o),
  .sclk_fall(sclk_fall), .cs_rise(cs_rise), .word_q(word_q)
);

// File: tb/adc_sout_tb.sv
module adc_sout_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int W     = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] conv = '0;
  logic         sdo, oe, pdn;
  logic [2:0]   st;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_sout #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .conv_word_i(conv), .sdo_o(sdo), .sdo_oe_o(oe), .pdn_o(pdn), .state_o(st)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial clock period, with the R10 high-phase hold check
  task automatic pulse();
    logic prev;
    prev = sdo;
    sclk = 1'b1;
    wait_cyc(HALF);
    chk("R10 sdo stable high phase", sdo, prev);
    sclk = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic run_frame(input logic [W-1:0] w, input int nz);
    conv = w;
    cs_n = 1'b0;
    wait_cyc(HALF);
    chk("R4 sample entry", st, 1);
    chk("R3 oe off in sample", oe, 0);
    pulse();
    chk("R4 still sample", st, 1);
    pulse();
    chk("R4 null state", st, 2);
    chk("R5 null bit", sdo, 0);
    chk("R3 oe on", oe, 1);
    conv = ~w;  // R11: later input must not leak in
    for (int i = 0; i < W; i++) begin
      pulse();
      chk("R13 msb code", st, 3);
      chk("R6 R11 msb bit", sdo, w[W-1-i]);
      chk("R9 pdn low", pdn, 0);
    end
    for (int i = 0; i < W-1; i++) begin
      pulse();
      chk("R13 lsb code", st, 4);
      chk("R7 R11 lsb bit", sdo, w[1+i]);
      chk("R9 pdn high", pdn, 1);
    end
    for (int i = 0; i < nz; i++) begin
      pulse();
      chk("R8 zeros state", st, 5);
      chk("R8 zero bit", sdo, 0);
      chk("R9 pdn in zeros", pdn, 1);
    end
    cs_n = 1'b1;
    wait_cyc(HALF);
    chk("R12 idle after frame", st, 0);
    chk("R3 oe off idle", oe, 0);
    chk("R12 pdn off", pdn, 0);
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 reset state", st, 0);
    chk("R1 reset oe", oe, 0);
    chk("R1 reset pdn", pdn, 0);
    rst_n = 1'b1;
    wait_cyc(HALF);
    chk("R1 post reset state", st, 0);
    chk("R1 post reset oe", oe, 0);

    run_frame(12'hA5A, 3);
    run_frame(12'h5A5, 40);
    run_frame(12'h000, 2);
    run_frame(12'hFFF, 2);
    for (int b = 0; b < W; b++) begin
      run_frame(W'(1) << b, 1);
      run_frame(~(W'(1) << b), 1);
    end

    // R12: abort at every point of the frame
    for (int k = 0; k < 2*W + 4; k++) begin
      conv = W'(k * 37 + 5);
      cs_n = 1'b0;
      wait_cyc(HALF);
      for (int p = 0; p < k; p++) pulse();
      cs_n = 1'b1;
      wait_cyc(HALF);
      chk("R12 abort state", st, 0);
      chk("R12 abort oe", oe, 0);
      chk("R12 abort pdn", pdn, 0);
    end
    run_frame(12'h3C6, 2);

    // R2: select low through reset
    cs_n = 1'b0;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(HALF);
    for (int p = 0; p < 6; p++) begin
      pulse();
      chk("R2 ignored clocks state", st, 0);
      chk("R2 ignored clocks oe", oe, 0);
    end
    cs_n = 1'b1;
    wait_cyc(HALF);
    chk("R2 still idle", st, 0);
    run_frame(12'h9B1, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule